// File: doc/BRIEF.md
# Gain-Trim Potentiometer Controller

This block keeps a 10-bit digital potentiometer, used to trim the gain of a converter, loaded with the right setting. It has one host-visible control word and four calibration words, one for each of the converter's voltage ranges. The calibration words are filled from a non-volatile store through a simple request/acknowledge read port. This happens once after reset, and again whenever the host asks for it. Every command to the potentiometer leaves through a second request/acknowledge port. There are two kinds of command: wiper write, and store-wiper-to-nonvolatile.

The host uses the control word to write a wiper value directly, to start a calibration reload, or to make the potentiometer keep its present wiper. Each of these actions is started by a command bit that clears itself when the action has finished. The controller also watches the selected range input. Whenever that input changes, and whenever a reload completes, the controller writes the matching calibration word to the wiper. Only one sequencer drives both ports, so the actions never overlap. When several actions are waiting, they are served in a fixed priority order.

Top module: `potcal_ctrl`

## Requirements
- R1: After reset, the reload bit (bit 14 of the control word) reads 1. The block reads non-volatile entries 0, 1, 2 and 3 in that order, and stores entry k in calibration word k.
- R2: When a reload completes, exactly one wiper write follows, carrying the calibration word of the range selected at that moment.
- R3: Each change of `range_sel` produces exactly one wiper write (`pot_op`=0) carrying the calibration word of the new range. Without changes, no commands are issued.
- R4: Writing the control word with bit 15 = 1 issues one wiper write carrying bits 9..0 of the word. Bit 15 reads 1 until the potentiometer acknowledges, then reads 0. Bits 9..0 and 12..10 keep the values written.
- R5: Writing bit 14 = 1 reloads all four calibration words from the non-volatile port. Bit 14 reads 1 until the last entry arrives, then reads 0.
- R6: Writing bit 13 = 1 issues one store command (`pot_op`=1). Bit 13 clears when that command is acknowledged, and the wiper field is left unchanged.
- R7: Pending actions are served in this order: reload, then range load, then control-word wiper write, then store. An action already in flight is finished first.
- R8: Calibration word k is read at word address 0x11+k, with the value in bits 9..0 and bits 15..10 reading 0. Host writes to these addresses are ignored.
- R9: The control word is at word address 0x10. Any other unmapped address reads 0. A command bit written as 0 does not cancel a pending action.
- R10: A request stays high, with its index, op and data stable, until it is acknowledged. `nv_req` and `pot_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also acts as boot |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 5 | Host word address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data (combinational from address) |
| range_sel | input | 2 | Selected converter voltage range |
| nv_req | output | 1 | Non-volatile read request |
| nv_idx | output | 2 | Entry being read |
| nv_ack | input | 1 | Read acknowledge; `nv_data` is valid with it |
| nv_data | input | 10 | Calibration entry from the store |
| pot_req | output | 1 | Potentiometer command request |
| pot_op | output | 1 | 0 = wiper write, 1 = store wiper to nonvolatile |
| pot_wdata | output | 10 | Wiper value for a write command |
| pot_ack | input | 1 | Command acknowledge |

## Verification
The assertions assume that both acknowledges behave as handshakes. Each acknowledge is high for only one cycle at a time, and only while its matching request is high. `nv_data` is meaningful only in an acknowledge cycle. The bench models respect this: they raise an acknowledge on the falling edge only when the request is high and the acknowledge was low, and they drop it on the next falling edge. The potentiometer model can withhold acknowledges for any length of time, so that several actions queue up. The range input is changed only on falling edges.

// File: rtl/potcal_pkg.sv
package potcal_pkg;
    localparam int CW_W      = 16;
    localparam int BIT_LOAD  = 15;
    localparam int BIT_RELD  = 14;
    localparam int BIT_KEEP  = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_RANGE = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_KEEP  = 2'd2
    } cmd_kind_t;

    localparam logic OP_WIPER = 1'b0;
    localparam logic OP_STORE = 1'b1;
endpackage

// File: rtl/potcal_range_watch.sv
module potcal_range_watch #(
    parameter int RANGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RANGE_W-1:0] range_sel,
    output logic               range_chg
);
    logic [RANGE_W-1:0] range_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) range_q <= '0;
        else        range_q <= range_sel;
    end

    assign range_chg = (range_q != range_sel);
endmodule

// File: rtl/potcal_regfile.sv
module potcal_regfile
    import potcal_pkg::*;
#(
    parameter int                WIPER_W = 10,
    parameter int                NRANGE  = 4,
    parameter int                ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] BASE    = 5'h10,
    parameter int                IDX_W   = $clog2(NRANGE)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [CW_W-1:0]                 wdata,
    output logic [CW_W-1:0]                 rdata,
    input  logic                            load_clr,
    input  logic                            reld_clr,
    input  logic                            keep_clr,
    input  logic                            cal_we,
    input  logic [IDX_W-1:0]                cal_idx,
    input  logic [WIPER_W-1:0]              cal_din,
    output logic                            load_q,
    output logic                            reld_q,
    output logic                            keep_q,
    output logic [WIPER_W-1:0]              wiper_q,
    output logic [NRANGE-1:0][WIPER_W-1:0]  cal_q
);
    localparam int SPARE_LO = WIPER_W;
    localparam int SPARE_W  = BIT_KEEP - WIPER_W;

    logic                ctl_hit;
    logic [SPARE_W-1:0]  spare_q;

    assign ctl_hit = wr_en && (addr == BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            reld_q  <= 1'b1;
            keep_q  <= 1'b0;
            wiper_q <= '0;
            spare_q <= '0;
        end else begin
            load_q <= (load_q & ~load_clr) | (ctl_hit & wdata[BIT_LOAD]);
            reld_q <= (reld_q & ~reld_clr) | (ctl_hit & wdata[BIT_RELD]);
            keep_q <= (keep_q & ~keep_clr) | (ctl_hit & wdata[BIT_KEEP]);
            if (ctl_hit) begin
                wiper_q <= wdata[WIPER_W-1:0];
                spare_q <= wdata[SPARE_LO +: SPARE_W];
            end
        end
    end

    for (genvar k = 0; k < NRANGE; k++) begin : g_cal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  cal_q[k] <= '0;
            else if (cal_we && cal_idx == IDX_W'(k))     cal_q[k] <= cal_din;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == BASE) begin
            rdata[BIT_LOAD]              = load_q;
            rdata[BIT_RELD]              = reld_q;
            rdata[BIT_KEEP]              = keep_q;
            rdata[SPARE_LO +: SPARE_W]   = spare_q;
            rdata[WIPER_W-1:0]           = wiper_q;
        end
        for (int k = 0; k < NRANGE; k++) begin
            if (addr == ADDR_W'(int'(BASE) + 1 + k))
                rdata[WIPER_W-1:0] = cal_q[k];
        end
    end
endmodule

// File: rtl/potcal_seq.sv
module potcal_seq
    import potcal_pkg::*;
#(
    parameter int WIPER_W = 10,
    parameter int NRANGE  = 4,
    parameter int IDX_W   = $clog2(NRANGE)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_q,
    input  logic                            reld_q,
    input  logic                            keep_q,
    input  logic [WIPER_W-1:0]              wiper_q,
    input  logic [NRANGE-1:0][WIPER_W-1:0]  cal_q,
    input  logic [IDX_W-1:0]                range_sel,
    input  logic                            range_chg,
    output logic                            nv_req,
    output logic [IDX_W-1:0]                nv_idx,
    input  logic                            nv_ack,
    input  logic [WIPER_W-1:0]              nv_data,
    output logic                            pot_req,
    output logic                            pot_op,
    output logic [WIPER_W-1:0]              pot_wdata,
    input  logic                            pot_ack,
    output logic                            load_clr,
    output logic                            reld_clr,
    output logic                            keep_clr,
    output logic                            cal_we,
    output logic [IDX_W-1:0]                cal_idx,
    output logic [WIPER_W-1:0]              cal_din
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NRANGE - 1);

    seq_state_t          state_q, state_d;
    cmd_kind_t           kind_q;
    logic [IDX_W-1:0]    idx_q;
    logic [WIPER_W-1:0]  data_q;
    logic                range_pend_q;

    logic fetch_last;
    logic pick_reload, pick_range, pick_load, pick_keep;

    assign fetch_last  = (state_q == ST_FETCH) && nv_ack && (idx_q == LAST_IDX);
    assign pick_reload = (state_q == ST_IDLE) && reld_q;
    assign pick_range  = (state_q == ST_IDLE) && !reld_q && range_pend_q;
    assign pick_load   = (state_q == ST_IDLE) && !reld_q && !range_pend_q && load_q;
    assign pick_keep   = (state_q == ST_IDLE) && !reld_q && !range_pend_q && !load_q && keep_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_reload)                                 state_d = ST_FETCH;
                else if (pick_range || pick_load || pick_keep)   state_d = ST_ISSUE;
            end
            ST_FETCH: if (fetch_last) state_d = ST_IDLE;
            ST_ISSUE: if (pot_ack)    state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q       <= CMD_RANGE;
            idx_q        <= '0;
            data_q       <= '0;
            range_pend_q <= 1'b0;
        end else begin
            if (pick_reload) idx_q <= '0;
            else if (state_q == ST_FETCH && nv_ack) idx_q <= idx_q + 1'b1;

            if (pick_range) begin
                kind_q <= CMD_RANGE;
                data_q <= cal_q[range_sel];
            end else if (pick_load) begin
                kind_q <= CMD_LOAD;
                data_q <= wiper_q;
            end else if (pick_keep) begin
                kind_q <= CMD_KEEP;
            end

            range_pend_q <= (range_pend_q & ~pick_range) | range_chg | fetch_last;
        end
    end

    // outputs
    always_comb begin
        nv_req    = (state_q == ST_FETCH);
        nv_idx    = idx_q;
        pot_req   = (state_q == ST_ISSUE);
        pot_op    = (kind_q == CMD_KEEP) ? OP_STORE : OP_WIPER;
        pot_wdata = data_q;
        cal_we    = (state_q == ST_FETCH) && nv_ack;
        cal_idx   = idx_q;
        cal_din   = nv_data;
        reld_clr  = fetch_last;
        load_clr  = (state_q == ST_ISSUE) && pot_ack && (kind_q == CMD_LOAD);
        keep_clr  = (state_q == ST_ISSUE) && pot_ack && (kind_q == CMD_KEEP);
    end
endmodule

// File: rtl/potcal_ctrl.sv
module potcal_ctrl
    import potcal_pkg::*;
#(
    parameter int WIPER_W = 10,
    parameter int NRANGE  = 4,
    parameter int ADDR_W  = 5,
    parameter int RANGE_W = $clog2(NRANGE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [RANGE_W-1:0] range_sel,
    output logic               nv_req,
    output logic [RANGE_W-1:0] nv_idx,
    input  logic               nv_ack,
    input  logic [WIPER_W-1:0] nv_data,
    output logic               pot_req,
    output logic               pot_op,
    output logic [WIPER_W-1:0] pot_wdata,
    input  logic               pot_ack
);
    logic                           load_q, reld_q, keep_q;
    logic                           load_clr, reld_clr, keep_clr;
    logic [WIPER_W-1:0]             wiper_q;
    logic [NRANGE-1:0][WIPER_W-1:0] cal_q;
    logic                           cal_we;
    logic [RANGE_W-1:0]             cal_idx;
    logic [WIPER_W-1:0]             cal_din;
    logic                           range_chg;

    potcal_regfile #(
        .WIPER_W(WIPER_W), .NRANGE(NRANGE), .ADDR_W(ADDR_W),
        .BASE(ADDR_W'(16)), .IDX_W(RANGE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .load_clr(load_clr), .reld_clr(reld_clr), .keep_clr(keep_clr),
        .cal_we(cal_we), .cal_idx(cal_idx), .cal_din(cal_din),
        .load_q(load_q), .reld_q(reld_q), .keep_q(keep_q),
        .wiper_q(wiper_q), .cal_q(cal_q)
    );

    potcal_range_watch #(.RANGE_W(RANGE_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .range_chg(range_chg)
    );

    potcal_seq #(.WIPER_W(WIPER_W), .NRANGE(NRANGE), .IDX_W(RANGE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load_q(load_q), .reld_q(reld_q), .keep_q(keep_q),
        .wiper_q(wiper_q), .cal_q(cal_q),
        .range_sel(range_sel), .range_chg(range_chg),
        .nv_req(nv_req), .nv_idx(nv_idx), .nv_ack(nv_ack), .nv_data(nv_data),
        .pot_req(pot_req), .pot_op(pot_op), .pot_wdata(pot_wdata), .pot_ack(pot_ack),
        .load_clr(load_clr), .reld_clr(reld_clr), .keep_clr(keep_clr),
        .cal_we(cal_we), .cal_idx(cal_idx), .cal_din(cal_din)
    );
endmodule

// File: rtl/potcal_chk.sv
module potcal_chk #(
    parameter int WIPER_W = 10,
    parameter int RANGE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nv_req,
    input logic [RANGE_W-1:0] nv_idx,
    input logic               nv_ack,
    input logic               pot_req,
    input logic               pot_op,
    input logic [WIPER_W-1:0] pot_wdata,
    input logic               pot_ack,
    input logic               load_q,
    input logic               reld_q,
    input logic               keep_q
);
    localparam logic [RANGE_W-1:0] LAST = '1;

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_req && pot_req));

    a_r10_pot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_req && !pot_ack) |=> (pot_req && $stable(pot_op) && $stable(pot_wdata)));

    a_r10_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && !nv_ack) |=> (nv_req && $stable(nv_idx)));

    a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_ack && nv_idx != LAST) |=> (nv_req && nv_idx == $past(nv_idx) + 1'b1));

    a_r5_reload_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reld_q) |-> $past(nv_ack && nv_idx == LAST));

    a_r4_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_q) |-> $past(pot_ack && pot_op == 1'b0));

    a_r6_keep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(keep_q) |-> $past(pot_ack && pot_op == 1'b1));

    a_r7_reload_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pot_req) |-> !$past(reld_q));
endmodule

bind potcal_ctrl potcal_chk #(.WIPER_W(WIPER_W), .RANGE_W(RANGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .nv_idx(nv_idx), .nv_ack(nv_ack),
    .pot_req(pot_req), .pot_op(pot_op), .pot_wdata(pot_wdata), .pot_ack(pot_ack),
    .load_q(load_q), .reld_q(reld_q), .keep_q(keep_q)
);

// File: tb/tb_potcal_ctrl.sv
module tb_potcal_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  range_sel = 2'd2;
    logic        nv_req;
    logic [1:0]  nv_idx;
    logic        nv_ack = 1'b0;
    logic [9:0]  nv_data = '0;
    logic        pot_req;
    logic        pot_op;
    logic [9:0]  pot_wdata;
    logic        pot_ack = 1'b0;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int seed = 1, nv_cnt = 0, log_n = 0, cur = 2;
    bit pot_go = 1'b1;
    logic       log_op [0:127];
    logic [9:0] log_dat [0:127];
    logic [9:0] cal_exp [0:3];

    always #10 clk = ~clk;

    potcal_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .range_sel(range_sel),
        .nv_req(nv_req), .nv_idx(nv_idx), .nv_ack(nv_ack), .nv_data(nv_data),
        .pot_req(pot_req), .pot_op(pot_op), .pot_wdata(pot_wdata), .pot_ack(pot_ack)
    );

    function automatic logic [9:0] nv_val(int s, int k);
        return 10'((s * 145 + k * 107 + 33) & 1023);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // non-volatile store model; also checks the fetch order
    always @(negedge clk) begin
        if (nv_req && !nv_ack) begin
            check("R1 nv order", 32'(nv_idx), 32'(nv_cnt % 4));
            nv_cnt++;
            nv_data = nv_val(seed, int'(nv_idx));
            nv_ack = 1'b1;
        end else begin
            nv_ack = 1'b0;
        end
    end

    // potentiometer model with command log
    always @(negedge clk) begin
        if (pot_req && !pot_ack && pot_go) begin
            log_op[log_n % 128]  = pot_op;
            log_dat[log_n % 128] = pot_wdata;
            log_n++;
            pot_ack = 1'b1;
        end else begin
            pot_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog got=%0d exp=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic bus_write(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_pot(int n);
        for (int i = 0; i < 300 && log_n < n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_cmd(string tag, int i, logic op, logic [9:0] d);
        check({tag, " op"}, 32'(log_op[i]), 32'(op));
        check({tag, " data"}, 32'(log_dat[i]), 32'(d));
    endtask

    task automatic go_range(int r);
        int n;
        if (r == cur) return;
        n = log_n;
        @(negedge clk);
        range_sel = 2'(r);
        wait_pot(n + 1);
        check("R3 one write per change", 32'(log_n), 32'(n + 1));
        check_cmd("R3 range load", n, 1'b0, cal_exp[r]);
        cur = r;
    endtask

    initial begin
        logic [15:0] rd;
        logic [9:0]  vals [0:5];
        int n;
        vals[0] = 10'h000; vals[1] = 10'h3FF; vals[2] = 10'h155;
        vals[3] = 10'h2AA; vals[4] = 10'h001; vals[5] = 10'h200;

        repeat (3) @(negedge clk);
        bus_read(5'h10, rd);
        check("R1 reset reload pending", 32'(rd), 32'h4000);
        rst_n = 1'b1;

        // boot reload and follow-up range load
        wait_pot(1);
        for (int k = 0; k < 4; k++) begin
            cal_exp[k] = nv_val(seed, k);
            bus_read(5'(17 + k), rd);
            check("R1 cal loaded", 32'(rd), 32'(cal_exp[k]));
        end
        check("R1 four fetches", 32'(nv_cnt), 32'd4);
        bus_read(5'h10, rd);
        check("R5 reload bit cleared", 32'(rd), 32'h0);
        check("R2 one write after boot", 32'(log_n), 32'd1);
        check_cmd("R2 boot load", 0, 1'b0, cal_exp[2]);

        // every ordered pair of ranges
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                if (a != b) begin
                    go_range(a);
                    go_range(b);
                end
        n = log_n;
        repeat (20) @(negedge clk);
        check("R3 no spurious command", 32'(log_n), 32'(n));

        // direct wiper writes with scratch bits
        for (int i = 0; i < 6; i++) begin
            logic [15:0] w;
            w = {3'b100, 3'(i + 1), vals[i]};
            n = log_n;
            bus_write(5'h10, w);
            bus_read(5'h10, rd);
            check("R4 load bit set", 32'(rd[15]), 32'd1);
            wait_pot(n + 1);
            check_cmd("R4 wiper write", n, 1'b0, vals[i]);
            bus_read(5'h10, rd);
            check("R4 readback", 32'(rd), 32'({3'b000, 3'(i + 1), vals[i]}));
        end

        // store command
        n = log_n;
        bus_write(5'h10, {3'b001, 3'b000, 10'h123});
        wait_pot(n + 1);
        check("R6 store op", 32'(log_n), 32'(n + 1));
        check("R6 op code", 32'(log_op[n]), 32'd1);
        bus_read(5'h10, rd);
        check("R6 store cleared", 32'(rd), 32'h0123);

        // command bit written as 0 does not cancel, unmapped reads
        bus_read(5'h0F, rd);
        check("R9 unmapped low", 32'(rd), 32'd0);
        bus_read(5'h15, rd);
        check("R9 unmapped high", 32'(rd), 32'd0);

        // calibration words ignore writes
        n = log_n;
        for (int k = 0; k < 4; k++) bus_write(5'(17 + k), 16'hFFFF);
        repeat (5) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            bus_read(5'(17 + k), rd);
            check("R8 cal read-only", 32'(rd), 32'(cal_exp[k]));
        end
        check("R8 no command", 32'(log_n), 32'(n));

        // host reload with new store contents
        seed = 7;
        n = log_n;
        bus_write(5'h10, 16'h4000);
        bus_read(5'h10, rd);
        check("R5 reload bit set", 32'(rd[14]), 32'd1);
        wait_pot(n + 1);
        for (int k = 0; k < 4; k++) begin
            cal_exp[k] = nv_val(seed, k);
            bus_read(5'(17 + k), rd);
            check("R5 cal reloaded", 32'(rd), 32'(cal_exp[k]));
        end
        check_cmd("R2 load after reload", n, 1'b0, cal_exp[cur]);

        // priority: queue everything behind a stalled write
        pot_go = 1'b0;
        seed = 11;
        n = log_n;
        bus_write(5'h10, {6'b100000, 10'h0AB});
        repeat (3) @(negedge clk);
        bus_write(5'h10, {6'b011000, 10'h0CD});
        bus_write(5'h10, {6'b000000, 10'h0CD});
        bus_read(5'h10, rd);
        check("R9 zero write keeps pending", 32'(rd[15:13]), 32'b111);
        @(negedge clk);
        range_sel = 2'((cur + 1) % 4);
        cur = (cur + 1) % 4;
        repeat (5) @(negedge clk);
        check("R7 stalled", 32'(log_n), 32'(n));
        pot_go = 1'b1;
        wait_pot(n + 3);
        for (int k = 0; k < 4; k++) cal_exp[k] = nv_val(seed, k);
        check("R7 command count", 32'(log_n), 32'(n + 3));
        check_cmd("R7 in-flight first", n, 1'b0, 10'h0AB);
        check_cmd("R7 range after reload", n + 1, 1'b0, cal_exp[cur]);
        check("R7 store last", 32'(log_op[n + 2]), 32'd1);
        bus_read(5'h10, rd);
        check("R7 all bits cleared", 32'(rd), 32'h00CD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule